// File: doc/BRIEF.md
# Descriptor-Driven Memory CRC Checker

This block verifies a stretch of memory against a checksum recorded in a small table that also lives in memory. Software or a boot sequencer hands it the address of a 16-byte descriptor and pulses a start strobe. The block fetches the descriptor over a 32-bit read port and checks three things. The descriptor must carry a fixed marker word. It must sit on a 16-byte boundary. It must lie in the same memory region as the range it describes. A region-map lookup port answers the question of which region an address belongs to.

When the descriptor is accepted, the checker reads the target range one word per cycle. It runs each word through a reflected CRC-32 and compares the result with the reference value stored in the descriptor. It finishes with a one-cycle done pulse, a status code and the computed CRC. A descriptor that breaks any rule finishes early with a bad-table code, and no target word is read.

Top module: `crc_table_checker`

## Requirements
- R1: After an accepted start, the checker reads descriptor words at descriptor address +0x0, +0x4, +0x8 and +0xC on four consecutive cycles. These words are the marker, the target start address, the target size in bytes and the reference CRC.
- R2: A marker word other than 0x43524349 ends the run with status 0x50, six cycles after start is sampled.
- R3: A descriptor address whose bits 3:0 are not all zero ends the run with status 0x50 in the cycle right after start is sampled, and no memory read is issued.
- R4: Bits 1:0 of the target start address and of the size are ignored. The range begins at the start with those bits cleared, and it covers size[31:2] words.
- R5: The effective region of the descriptor must equal that of the first and of the last target word, otherwise status 0x50. When the lookup flags an address as a sub-region, its parent id stands in for its own id. Status comes 7 cycles after start on a first-word mismatch and 8 cycles after start on a last-word mismatch.
- R6: A range whose end (start + size) lies beyond 2^32 gives status 0x50 after six cycles. A range ending exactly at 2^32 is accepted.
- R7: Target words are read one per cycle at consecutive ascending word addresses. The CRC uses the reflected 0x04C11DB7 polynomial with preset 0xFFFFFFFF and no final inversion, and each word is fed least-significant byte first.
- R8: A word count of zero performs no target reads. It reports the CRC 0xFFFFFFFF, compares that value against the reference, and finishes 7 cycles after start.
- R9: Done is high for exactly one cycle. Status is 0x01 when the CRC equals the reference and 0x02 when it differs. For N>0 target words, done comes 9+N cycles after start and the CRC output shows the computed value.
- R10: A start strobe that arrives while a run is in progress is ignored and does not change that run's reads, timing or result.
- R11: After reset, done is low, status is 0x00, the CRC output is 0 and no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a check (sampled only when idle) |
| desc_addr | input | 32 | Byte address of the descriptor |
| mem_req | output | 1 | Word read request |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_rdata | input | 32 | Read data, valid the cycle after the request |
| lkup_addr | output | 32 | Address presented to the region map |
| lkup_id | input | RGN_W | Region id of lkup_addr |
| lkup_sub | input | 1 | lkup_addr lies in a sub-region |
| lkup_parent | input | RGN_W | Parent region id when lkup_sub is set |
| done | output | 1 | One-cycle completion pulse |
| status | output | 8 | Result code (0x01 pass, 0x02 mismatch, 0x50 bad table) |
| crc_out | output | 32 | Computed CRC of the last completed range |

## Verification
The hardest cases to reach are the region rules. The first target word can resolve correctly while the last word crosses into a neighbouring region, and sub-region aliasing must work in both directions. The bench's region map decodes the top address nibble and marks one nibble as a child of another. Descriptors are placed so that each case is reached: a range straddles a region boundary, a descriptor sits in a child region while its target sits in the parent, and the reverse. A second start is also injected in the middle of a stream to show that it has no effect.

// File: rtl/crcchk_pkg.sv
package crcchk_pkg;
   localparam int unsigned WORD_W = 32;
   localparam logic [WORD_W-1:0] TABLE_MARK = 32'h4352_4349;
   localparam logic [WORD_W-1:0] CRC_PRESET = 32'hFFFF_FFFF;
   localparam logic [WORD_W-1:0] CRC_POLY_R = 32'hEDB8_8320;

   localparam logic [7:0] RES_NONE = 8'h00;
   localparam logic [7:0] RES_PASS = 8'h01;
   localparam logic [7:0] RES_MISS = 8'h02;
   localparam logic [7:0] RES_BAD  = 8'h50;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_FETCH,
      PH_RGN_DESC,
      PH_RGN_FIRST,
      PH_RGN_LAST,
      PH_STREAM
   } phase_t;
endpackage

// File: rtl/crcchk_crc_step.sv
module crcchk_crc_step #(
   parameter int unsigned DATA_W = 32,
   parameter logic [31:0] POLY_R = 32'hEDB8_8320,
   parameter logic [31:0] PRESET = 32'hFFFF_FFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              en,
   input  logic [DATA_W-1:0] data,
   output logic [31:0]       crc_q,
   output logic [31:0]       crc_nxt
);
   if (DATA_W == 0 || (DATA_W % 8) != 0) begin : g_bad_w
      $error("crcchk_crc_step: DATA_W must be a nonzero multiple of 8");
   end

   logic [31:0] chain [DATA_W+1];
   assign chain[0] = crc_q;

   // bit i of the word enters at stage i: LSB byte first, LSB bit first
   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      assign chain[i+1] = (chain[i][0] ^ data[i]) ?
                          ((chain[i] >> 1) ^ POLY_R) : (chain[i] >> 1);
   end

   assign crc_nxt = chain[DATA_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   crc_q <= PRESET;
      else if (clr) crc_q <= PRESET;
      else if (en)  crc_q <= crc_nxt;
   end

   // R7
   clr_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> crc_q == PRESET);
endmodule

// File: rtl/crcchk_rgn_resolve.sv
module crcchk_rgn_resolve #(
   parameter int unsigned RGN_W    = 4,
   parameter bit          ALIAS_EN = 1'b1
) (
   input  logic [RGN_W-1:0] id,
   input  logic             sub,
   input  logic [RGN_W-1:0] parent,
   output logic [RGN_W-1:0] eff
);
   if (ALIAS_EN) begin : g_alias
      assign eff = sub ? parent : id;
   end else begin : g_flat
      logic unused_alias;
      assign unused_alias = sub ^ (^parent);
      assign eff = id;
   end
endmodule

// File: rtl/crc_table_checker.sv
module crc_table_checker
   import crcchk_pkg::*;
#(
   parameter int unsigned RGN_W    = 4,
   parameter bit          ALIAS_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [31:0]      desc_addr,
   output logic             mem_req,
   output logic [31:0]      mem_addr,
   input  logic [31:0]      mem_rdata,
   output logic [31:0]      lkup_addr,
   input  logic [RGN_W-1:0] lkup_id,
   input  logic             lkup_sub,
   input  logic [RGN_W-1:0] lkup_parent,
   output logic             done,
   output logic [7:0]       status,
   output logic [31:0]      crc_out
);
   localparam int unsigned CNT_W   = WORD_W - 2;
   localparam int unsigned DESC_WD = 4;
   localparam int unsigned IDX_W   = $clog2(DESC_WD);

   if (RGN_W < 1 || RGN_W > 16) begin : g_bad_rgn
      $error("crc_table_checker: RGN_W out of range");
   end

   phase_t             ph;
   logic [IDX_W:0]     fcnt;
   logic [31:0]        dbase;
   logic [31:0]        dw [DESC_WD];
   logic [RGN_W-1:0]   rgn_desc;
   logic [RGN_W-1:0]   rgn_eff;
   logic [CNT_W-1:0]   issued, rcvd;
   logic               rv;
   logic [31:0]        crc_q, crc_nxt;

   // descriptor fields (bits 1:0 of start and size dropped)
   logic [31:0]        tgt_base, last_addr;
   logic [CNT_W-1:0]   nwords;
   logic [32:0]        span_end;
   logic               wraps;

   assign tgt_base  = {dw[1][31:2], 2'b00};
   assign nwords    = dw[2][31:2];
   assign last_addr = tgt_base + {nwords - CNT_W'(1), 2'b00};
   assign span_end  = {1'b0, tgt_base} + {1'b0, nwords, 2'b00};
   assign wraps     = span_end > 33'h1_0000_0000;

   crcchk_rgn_resolve #(.RGN_W(RGN_W), .ALIAS_EN(ALIAS_EN)) u_rgn (
      .id(lkup_id), .sub(lkup_sub), .parent(lkup_parent), .eff(rgn_eff)
   );

   crcchk_crc_step #(.DATA_W(WORD_W), .POLY_R(CRC_POLY_R), .PRESET(CRC_PRESET)) u_crc (
      .clk(clk), .rst_n(rst_n), .clr(ph == PH_RGN_FIRST), .en(rv),
      .data(mem_rdata), .crc_q(crc_q), .crc_nxt(crc_nxt)
   );

   always_comb begin
      unique case (ph)
         PH_RGN_FIRST: lkup_addr = tgt_base;
         PH_RGN_LAST:  lkup_addr = last_addr;
         default:      lkup_addr = dbase;
      endcase
   end

   assign mem_req  = (ph == PH_FETCH && fcnt < (IDX_W+1)'(DESC_WD)) ||
                     (ph == PH_STREAM && issued != nwords);
   assign mem_addr = (ph == PH_FETCH) ? dbase + {{(32-IDX_W-3){1'b0}}, fcnt, 2'b00}
                                      : tgt_base + {issued, 2'b00};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph       <= PH_IDLE;
         fcnt     <= '0;
         dbase    <= '0;
         for (int i = 0; i < DESC_WD; i++) dw[i] <= '0;
         rgn_desc <= '0;
         issued   <= '0;
         rcvd     <= '0;
         rv       <= 1'b0;
         done     <= 1'b0;
         status   <= RES_NONE;
         crc_out  <= '0;
      end else begin
         done <= 1'b0;
         rv   <= (ph == PH_STREAM) && mem_req;
         unique case (ph)
            PH_IDLE: if (start) begin
               if (desc_addr[3:0] != 4'h0) begin
                  done   <= 1'b1;
                  status <= RES_BAD;
               end else begin
                  dbase <= desc_addr;
                  fcnt  <= '0;
                  ph    <= PH_FETCH;
               end
            end
            PH_FETCH: begin
               if (fcnt != '0) dw[fcnt[IDX_W-1:0] - IDX_W'(1)] <= mem_rdata;
               if (fcnt == (IDX_W+1)'(DESC_WD)) ph <= PH_RGN_DESC;
               else fcnt <= fcnt + 1'b1;
            end
            PH_RGN_DESC: begin
               rgn_desc <= rgn_eff;
               if (dw[0] != TABLE_MARK || wraps) begin
                  done <= 1'b1; status <= RES_BAD; ph <= PH_IDLE;
               end else ph <= PH_RGN_FIRST;
            end
            PH_RGN_FIRST: begin
               issued <= '0;
               rcvd   <= '0;
               if (rgn_eff != rgn_desc) begin
                  done <= 1'b1; status <= RES_BAD; ph <= PH_IDLE;
               end else if (nwords == '0) begin
                  done    <= 1'b1;
                  crc_out <= CRC_PRESET;
                  status  <= (dw[3] == CRC_PRESET) ? RES_PASS : RES_MISS;
                  ph      <= PH_IDLE;
               end else ph <= PH_RGN_LAST;
            end
            PH_RGN_LAST: begin
               if (rgn_eff != rgn_desc) begin
                  done <= 1'b1; status <= RES_BAD; ph <= PH_IDLE;
               end else ph <= PH_STREAM;
            end
            PH_STREAM: begin
               if (mem_req) issued <= issued + 1'b1;
               if (rv) begin
                  rcvd <= rcvd + 1'b1;
                  if (rcvd == nwords - CNT_W'(1)) begin
                     done    <= 1'b1;
                     crc_out <= crc_nxt;
                     status  <= (crc_nxt == dw[3]) ? RES_PASS : RES_MISS;
                     ph      <= PH_IDLE;
                  end
               end
            end
            default: ph <= PH_IDLE;
         endcase
      end
   end

   // R1
   rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && $past(mem_req)) |-> mem_addr == $past(mem_addr) + 32'd4);
   // R3
   misalign_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_IDLE && start && desc_addr[3:0] != 4'h0) |=>
         (done && status == RES_BAD && !mem_req));
   // R2
   mark_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_RGN_DESC && dw[0] != TABLE_MARK) |=> (done && status == RES_BAD));
   // R9
   done_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (status == RES_PASS || status == RES_MISS || status == RES_BAD));
   // R10
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph != PH_IDLE && start) |=> $stable(dbase));
   // R8
   zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && status != RES_BAD && $past(ph) == PH_RGN_FIRST) |-> crc_out == CRC_PRESET);
endmodule

// File: tb/crc_table_checker_bench.sv
module crc_table_checker_bench;
   localparam int RW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [31:0] desc_addr = '0;
   logic mem_req;
   logic [31:0] mem_addr;
   logic [31:0] mem_rdata = '0;
   logic [31:0] lkup_addr;
   logic [RW-1:0] lkup_id, lkup_parent;
   logic lkup_sub;
   logic done;
   logic [7:0] status;
   logic [31:0] crc_out;

   int checks = 0;
   int failures = 0;
   int cyc = 0;

   logic [31:0] ovr [logic [31:0]];
   logic [31:0] exp_q [$];

   always #2 clk = ~clk;

   crc_table_checker #(.RGN_W(RW), .ALIAS_EN(1'b1)) u_crc_table_checker (
      .clk(clk), .rst_n(rst_n), .start(start), .desc_addr(desc_addr),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .lkup_addr(lkup_addr), .lkup_id(lkup_id), .lkup_sub(lkup_sub),
      .lkup_parent(lkup_parent), .done(done), .status(status), .crc_out(crc_out)
   );

   // region map: top nibble is the region, nibble 5 is a child of nibble 4
   assign lkup_id     = lkup_addr[31:28];
   assign lkup_sub    = (lkup_addr[31:28] == 4'h5);
   assign lkup_parent = lkup_sub ? 4'h4 : lkup_addr[31:28];

   function automatic logic [31:0] mem_word(logic [31:0] a);
      if (ovr.exists(a)) return ovr[a];
      return (a * 32'h9E37_79B1) ^ 32'h1234_5678;
   endfunction

   always @(posedge clk) if (mem_req) mem_rdata <= mem_word(mem_addr);

   function automatic logic [31:0] crc_words(logic [31:0] base, int n);
      logic [31:0] c = 32'hFFFF_FFFF;
      for (int w = 0; w < n; w++) begin
         logic [31:0] v = mem_word(base + 32'(4 * w));
         for (int b = 0; b < 4; b++) begin
            c = c ^ {24'h0, v[8*b +: 8]};
            for (int k = 0; k < 8; k++)
               c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
         end
      end
      return c;
   endfunction

   task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run_case(string req, logic [31:0] da, logic [31:0] mark,
                           logic [31:0] sa, logic [31:0] sz, logic [31:0] rf,
                           int lat, logic [7:0] est, bit chk_crc, logic [31:0] ecrc,
                           bit rd_desc, int nrd, int inj_k);
      ovr.delete();
      ovr[da] = mark; ovr[da + 4] = sa; ovr[da + 8] = sz; ovr[da + 12] = rf;
      exp_q.delete();
      if (rd_desc) for (int i = 0; i < 4; i++) exp_q.push_back(da + 32'(4 * i));
      for (int i = 0; i < nrd; i++) exp_q.push_back({sa[31:2], 2'b00} + 32'(4 * i));
      @(negedge clk);
      start = 1'b1; desc_addr = da;
      for (int k = 0; k <= lat + 2; k++) begin
         @(negedge clk);
         start = (k == inj_k);
         if (k == inj_k) desc_addr = 32'h1000_0108;
         if (mem_req) begin
            if (exp_q.size() == 0) check(1'b0, {req, " extra read"}, mem_addr, 32'h0);
            else begin
               logic [31:0] e = exp_q.pop_front();
               check(mem_addr == e, {req, " read address"}, mem_addr, e);
            end
         end
         check(done == (k == lat), {req, " done timing"}, 32'(done), 32'(k == lat));
         if (k == lat) begin
            check(status == est, {req, " status"}, 32'(status), 32'(est));
            if (chk_crc) check(crc_out == ecrc, {req, " crc"}, crc_out, ecrc);
         end
      end
      start = 1'b0;
      check(exp_q.size() == 0, {req, " reads left"}, 32'(exp_q.size()), 32'h0);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 100000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
         end
      end
   end

   initial begin
      logic [31:0] c;
      repeat (3) @(negedge clk);
      // R11 reset state
      check(done == 0 && mem_req == 0, "R11 done/req", {30'h0, done, mem_req}, 32'h0);
      check(status == 8'h00, "R11 status", 32'(status), 32'h0);
      check(crc_out == 32'h0, "R11 crc", crc_out, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R7 R9 eight words, matching reference
      c = crc_words(32'h1000_1000, 8);
      run_case("R7", 32'h1000_0100, 32'h4352_4349, 32'h1000_1000, 32'h20, c,
               17, 8'h01, 1, c, 1, 8, -1);
      // R9 mismatch
      run_case("R9", 32'h1000_0100, 32'h4352_4349, 32'h1000_1000, 32'h20, c ^ 32'h1,
               17, 8'h02, 1, c, 1, 8, -1);
      // R4 low bits of start and size ignored
      c = crc_words(32'h1000_2000, 4);
      run_case("R4", 32'h1000_0100, 32'h4352_4349, 32'h1000_2002, 32'h13, c,
               13, 8'h01, 1, c, 1, 4, -1);
      // R2 bad marker
      run_case("R2", 32'h1000_0100, 32'h4352_4348, 32'h1000_1000, 32'h20, 32'h0,
               6, 8'h50, 0, 32'h0, 1, 0, -1);
      // R3 misaligned descriptor
      run_case("R3", 32'h1000_0108, 32'h4352_4349, 32'h1000_1000, 32'h20, 32'h0,
               0, 8'h50, 0, 32'h0, 0, 0, -1);
      // R5 first word in another region
      run_case("R5", 32'h1000_0200, 32'h4352_4349, 32'h2000_0000, 32'h8, 32'h0,
               7, 8'h50, 0, 32'h0, 1, 0, -1);
      // R5 last word crosses into another region
      run_case("R5", 32'h1000_0200, 32'h4352_4349, 32'h1FFF_FFF8, 32'h10, 32'h0,
               8, 8'h50, 0, 32'h0, 1, 0, -1);
      // R5 descriptor in child region, target in parent
      c = crc_words(32'h4000_0040, 3);
      run_case("R5", 32'h5000_0400, 32'h4352_4349, 32'h4000_0040, 32'hC, c,
               12, 8'h01, 1, c, 1, 3, -1);
      // R5 descriptor in parent, target in child
      c = crc_words(32'h5000_0000, 2);
      run_case("R5", 32'h4000_0300, 32'h4352_4349, 32'h5000_0000, 32'h8, c,
               11, 8'h01, 1, c, 1, 2, -1);
      // R8 zero size, preset matches
      run_case("R8", 32'h1000_0100, 32'h4352_4349, 32'h1000_1000, 32'h0, 32'hFFFF_FFFF,
               7, 8'h01, 1, 32'hFFFF_FFFF, 1, 0, -1);
      // R8 R4 size below one word counts as zero, reference differs
      run_case("R8", 32'h1000_0100, 32'h4352_4349, 32'h1000_1000, 32'h3, 32'h0,
               7, 8'h02, 1, 32'hFFFF_FFFF, 1, 0, -1);
      // R6 range wraps past the top
      run_case("R6", 32'hF000_0000, 32'h4352_4349, 32'hFFFF_FFF0, 32'h20, 32'h0,
               6, 8'h50, 0, 32'h0, 1, 0, -1);
      // R6 range ending exactly at the top is accepted
      c = crc_words(32'hFFFF_FFF0, 4);
      run_case("R6", 32'hF000_0010, 32'h4352_4349, 32'hFFFF_FFF0, 32'h10, c,
               13, 8'h01, 1, c, 1, 4, -1);
      // R10 start during a run is ignored
      c = crc_words(32'h1000_1000, 8);
      run_case("R10", 32'h1000_0100, 32'h4352_4349, 32'h1000_1000, 32'h20, c,
               17, 8'h01, 1, c, 1, 8, 4);
      run_case("R10", 32'h1000_0100, 32'h4352_4349, 32'h1000_1000, 32'h20, c,
               17, 8'h01, 1, c, 1, 8, 12);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule